// File: doc/BRIEF.md
# Programmable Square-Wave Clock Generator

This block turns the system clock into a square wave whose rate is set by software through a small write port. It is a numerically controlled oscillator. A prescaler divides the clock by a power of two, and each prescaler tick adds a 16-bit tuning word into a 16-bit phase accumulator. The top bit of the accumulator is the square wave. For a 20 MHz system clock, the rate select k gives an update rate of 20 MHz / 2^k, from 20 MHz down to 156.25 kHz. The output frequency is then word × (20 MHz / 2^k) / 65536.

The wave is only sent to general-purpose pins that meet two conditions. The pin must be able to carry a generated signal, which is a build-time mask. The pin must also be currently switched to the generated-signal mode. A stop request halts the generator, clears the phase and forces every pin low. A readback path always presents the stored tuning word and rate code. A write with an out-of-range rate code is dropped.

Top module: `sqw_nco_gen`

## Requirements
- R1: After reset the stored tuning word and rate code read back as 0, the generator is stopped and every pin output is low.
- R2: A write with rate code below RATE_CNT (default 8; code k means update rate = clock / 2^k) stores word and code, visible on the readback one clock later, and starts the generator.
- R3: A write whose rate code is RATE_CNT or above is ignored. The readback, the phase and the pin outputs continue exactly as if no write had occurred.
- R4: After an accepted write, n clocks later the wave equals bit 15 of (word × floor(n / 2^k)) mod 65536. The accumulator advances once per 2^k clocks.
- R5: With word 0x8000 and k = 0 the wave alternates every clock, which is the highest output frequency (clock / 2).
- R6: With a tuning word of 0 the pin outputs stay low constantly.
- R7: A stop request forces all pins low from the next clock and clears the phase. The stored word and code stay readable.
- R8: When a stop request and a write arrive in the same clock, the stop wins and the write is discarded.
- R9: A pin carries the wave only if its bit is set in PIN_CAP (default: pins 0 and 4) and its mode input is set. All other pins stay low.
- R10: An accepted write while running restarts phase and prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for word and rate code |
| wr_word | input | ACC_W | Tuning word to store |
| wr_code | input | CODE_W | Rate code k; valid below RATE_CNT |
| stop_req | input | 1 | Stop generator, clear phase |
| pin_t_mode | input | PIN_N | Per-pin generated-signal mode enable |
| rd_word | output | ACC_W | Stored tuning word |
| rd_code | output | CODE_W | Stored rate code |
| pin_out | output | PIN_N | Gated square wave per pin |

## Verification
The bench builds the block with its default parameters: a 16-bit accumulator, eight rates, a 4-bit rate code and ten pins of which pins 0 and 4 are capable. The 4-bit code leaves codes 8 to 15 free, which makes the rejection path reachable. The ten-pin mask places capable pins next to pins that are not capable, so the gating rule is exercised on both kinds. The slowest rate, with a prescaler divide of 128, is kept within short runs so that phase wrap at every rate can be compared against the closed-form phase model.

// File: rtl/sqw_nco_pkg.sv
package sqw_nco_pkg;
   localparam int unsigned DEF_ACC_W    = 16;
   localparam int unsigned DEF_RATE_CNT = 8;
   localparam int unsigned DEF_PIN_N    = 10;

   // build a low-bit mask of width w with the lowest k bits set
   function automatic logic [31:0] low_mask(input int unsigned k);
      logic [31:0] m;
      m = '0;
      for (int unsigned i = 0; i < 32; i++) begin
         if (i < k) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/sqw_nco_prescale.sv
module sqw_nco_prescale #(
   parameter int unsigned RATE_CNT = 8,
   localparam int unsigned SEL_W   = $clog2(RATE_CNT),
   localparam int unsigned DIV_W   = RATE_CNT - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   import sqw_nco_pkg::*;

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      logic [31:0] full;
      full = low_mask(32'(sel));
      mask = full[DIV_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run || restart) cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && !restart && ((cnt_q & mask) == mask);
endmodule

// File: rtl/sqw_nco_phase.sv
module sqw_nco_phase #(
   parameter int unsigned ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic [ACC_W-1:0] word,
   output logic             wave
);
   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) acc_q <= '0;
      else if (tick)       acc_q <= acc_q + word;
   end

   assign wave = acc_q[ACC_W-1];
endmodule

// File: rtl/sqw_nco_pin_gate.sv
module sqw_nco_pin_gate #(
   parameter int unsigned PIN_N            = 10,
   parameter logic [PIN_N-1:0] PIN_CAP     = 10'b00_0001_0001
) (
   input  logic             enable,
   input  logic             wave,
   input  logic [PIN_N-1:0] mode,
   output logic [PIN_N-1:0] pins
);
   for (genvar i = 0; i < PIN_N; i++) begin : g_pin
      if (PIN_CAP[i]) begin : g_cap
         assign pins[i] = enable & mode[i] & wave;
      end else begin : g_nocap
         assign pins[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sqw_nco_gen.sv
module sqw_nco_gen #(
   parameter int unsigned ACC_W         = sqw_nco_pkg::DEF_ACC_W,
   parameter int unsigned RATE_CNT      = sqw_nco_pkg::DEF_RATE_CNT,
   parameter int unsigned PIN_N         = sqw_nco_pkg::DEF_PIN_N,
   parameter logic [PIN_N-1:0] PIN_CAP  = 10'b00_0001_0001,
   localparam int unsigned SEL_W        = $clog2(RATE_CNT),
   localparam int unsigned CODE_W       = SEL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ACC_W-1:0]  wr_word,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              stop_req,
   input  logic [PIN_N-1:0]  pin_t_mode,
   output logic [ACC_W-1:0]  rd_word,
   output logic [CODE_W-1:0] rd_code,
   output logic [PIN_N-1:0]  pin_out
);
   if (ACC_W < 2 || ACC_W > 32) begin : g_bad_acc
      $error("sqw_nco_gen: ACC_W must be 2..32");
   end
   if (RATE_CNT < 2 || RATE_CNT > 16 || (RATE_CNT & (RATE_CNT - 1)) != 0) begin : g_bad_rate
      $error("sqw_nco_gen: RATE_CNT must be a power of two in 2..16");
   end
   if (PIN_N < 1) begin : g_bad_pin
      $error("sqw_nco_gen: PIN_N must be at least 1");
   end

   logic [ACC_W-1:0] word_q;
   logic [SEL_W-1:0] sel_q;
   logic             on_q;
   logic             code_ok;
   logic             accept;
   logic             tick;
   logic             wave;

   assign code_ok = (wr_code < CODE_W'(RATE_CNT));
   assign accept  = wr_en && code_ok && !stop_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         sel_q  <= '0;
         on_q   <= 1'b0;
      end else if (stop_req) begin
         on_q   <= 1'b0;
      end else if (accept) begin
         word_q <= wr_word;
         sel_q  <= wr_code[SEL_W-1:0];
         on_q   <= 1'b1;
      end
   end

   sqw_nco_prescale #(.RATE_CNT(RATE_CNT)) i_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (on_q),
      .restart (accept),
      .sel     (sel_q),
      .tick    (tick)
   );

   sqw_nco_phase #(.ACC_W(ACC_W)) i_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (stop_req || accept || !on_q),
      .tick  (tick),
      .word  (word_q),
      .wave  (wave)
   );

   sqw_nco_pin_gate #(.PIN_N(PIN_N), .PIN_CAP(PIN_CAP)) i_gate (
      .enable (on_q),
      .wave   (wave),
      .mode   (pin_t_mode),
      .pins   (pin_out)
   );

   assign rd_word = word_q;
   assign rd_code = {1'b0, sel_q};
endmodule

// File: rtl/sqw_nco_gen_chk.sv
module sqw_nco_gen_chk #(
   parameter int unsigned ACC_W         = 16,
   parameter int unsigned RATE_CNT      = 8,
   parameter int unsigned PIN_N         = 10,
   parameter logic [PIN_N-1:0] PIN_CAP  = 10'b00_0001_0001,
   localparam int unsigned CODE_W       = $clog2(RATE_CNT) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ACC_W-1:0]  wr_word,
   input logic [CODE_W-1:0] wr_code,
   input logic              stop_req,
   input logic [PIN_N-1:0]  pin_t_mode,
   input logic [ACC_W-1:0]  rd_word,
   input logic [CODE_W-1:0] rd_code,
   input logic [PIN_N-1:0]  pin_out
);
   // R7: stop request clears pins on the next clock
   a_r7_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> (pin_out == '0));

   // R9: no pin carries the wave unless capable and selected
   a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~(pin_t_mode & PIN_CAP)) == '0);

   // R3: an out-of-range code leaves the settings untouched
   a_r3_reject_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_code >= CODE_W'(RATE_CNT)) |=> ($stable(rd_word) && $stable(rd_code)));

   // R2: accepted write is visible on readback
   a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !stop_req && wr_code < CODE_W'(RATE_CNT)) |=>
         (rd_word == $past(wr_word) && rd_code == $past(wr_code)));

   // R8: stop beats a simultaneous write
   a_r8_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && wr_en) |=> ($stable(rd_word) && pin_out == '0));

   // R6: a zero tuning word never raises a pin
   a_r6_zero_flat: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word == '0) |-> (pin_out == '0));
endmodule

bind sqw_nco_gen sqw_nco_gen_chk #(
   .ACC_W(ACC_W), .RATE_CNT(RATE_CNT), .PIN_N(PIN_N), .PIN_CAP(PIN_CAP)
) i_chk (.*);

// File: tb/test_sqw_nco_gen.sv
module test_sqw_nco_gen;
   localparam int unsigned ACC_W = 16;
   localparam int unsigned RATE_CNT = 8;
   localparam int unsigned PIN_N = 10;
   localparam int unsigned CODE_W = 4;
   localparam logic [PIN_N-1:0] CAP = 10'b00_0001_0001;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ACC_W-1:0]  wr_word = '0;
   logic [CODE_W-1:0] wr_code = '0;
   logic              stop_req = 1'b0;
   logic [PIN_N-1:0]  pin_t_mode = '0;
   logic [ACC_W-1:0]  rd_word;
   logic [CODE_W-1:0] rd_code;
   logic [PIN_N-1:0]  pin_out;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // reference model state
   longint m_word = 0;
   int     m_k = 0;
   bit     m_on = 0;
   longint m_n = 0;

   always #5 clk = ~clk;

   sqw_nco_gen i_sqw_nco_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_code(wr_code),
      .stop_req(stop_req), .pin_t_mode(pin_t_mode),
      .rd_word(rd_word), .rd_code(rd_code), .pin_out(pin_out)
   );

   function automatic logic [PIN_N-1:0] exp_pins();
      longint ph;
      logic w;
      ph = (m_word * (m_n >> m_k)) & 64'hFFFF;
      w = ph[15];
      return (m_on && w) ? (pin_t_mode & CAP) : '0;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, longint'(pin_out), longint'(exp_pins()));
      chk(tag, longint'(rd_word), m_word);
      chk(tag, longint'(rd_code), longint'(m_k));
   endtask

   // one clock: inputs already driven, update model, sample at negedge
   task automatic cyc();
      @(posedge clk);
      if (!rst_n) begin
         m_word = 0; m_k = 0; m_on = 0; m_n = 0;
      end else if (stop_req) begin
         m_on = 0; m_n = 0;
      end else if (wr_en && wr_code < CODE_W'(RATE_CNT)) begin
         m_word = longint'(wr_word); m_k = int'(wr_code); m_on = 1; m_n = 0;
      end else if (m_on) begin
         m_n++;
      end
      @(negedge clk);
      wr_en = 1'b0;
      stop_req = 1'b0;
   endtask

   task automatic do_write(input logic [ACC_W-1:0] w, input logic [CODE_W-1:0] c);
      wr_en = 1'b1; wr_word = w; wr_code = c;
      cyc();
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         cyc();
         check_all(tag);
      end
   endtask

   initial begin
      #(10 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [PIN_N-1:0] prev;
      void'($urandom(32'd1234));
      @(negedge clk);
      pin_t_mode = '1;
      cyc(); cyc();
      check_all("R1 reset state");
      rst_n = 1'b1;
      run(3, "R1 idle after reset");

      // R2 / R4 basic start
      do_write(16'h1234, 4'd2);
      check_all("R2 readback after write");
      run(40, "R4 phase k=2");

      // R5 top rate alternates
      do_write(16'h8000, 4'd0);
      prev = pin_out;
      for (int i = 0; i < 8; i++) begin
         cyc();
         check_all("R5 max rate");
         chk("R5 toggle", longint'(pin_out != prev), 1);
         prev = pin_out;
      end

      // R3 invalid code mid-run
      do_write(16'h9999, 4'd9);
      check_all("R3 invalid code ignored");
      run(10, "R3 running on after reject");
      do_write(16'h0001, 4'd15);
      check_all("R3 invalid code 15 ignored");

      // R6 zero word
      do_write(16'h0000, 4'd0);
      run(50, "R6 zero word flat");

      // R9 gating: only capable pins
      do_write(16'h4000, 4'd0);
      pin_t_mode = 10'b11_1110_1110;
      run(10, "R9 capable pins unselected");
      pin_t_mode = 10'b00_0001_0000;
      run(10, "R9 one pin selected");
      pin_t_mode = '1;

      // R10 restart while running
      do_write(16'h3000, 4'd1);
      run(7, "R10 before restart");
      do_write(16'h3000, 4'd1);
      check_all("R10 phase restarted");
      run(12, "R10 after restart");

      // R7 stop
      stop_req = 1'b1;
      cyc();
      chk("R7 pins low after stop", longint'(pin_out), 0);
      check_all("R7 settings kept");
      run(10, "R7 stays stopped");

      // R8 stop and write together
      do_write(16'hC000, 4'd0);
      run(3, "R8 running");
      stop_req = 1'b1; wr_en = 1'b1; wr_word = 16'h1111; wr_code = 4'd3;
      cyc();
      chk("R8 stop wins pins", longint'(pin_out), 0);
      chk("R8 write dropped", longint'(rd_word), 64'hC000);
      run(4, "R8 after");

      // random mix
      for (int s = 0; s < 40; s++) begin
         logic [CODE_W-1:0] c;
         c = ($urandom_range(0, 5) == 0) ? CODE_W'($urandom_range(8, 15))
                                         : CODE_W'($urandom_range(0, 7));
         pin_t_mode = PIN_N'($urandom);
         do_write(ACC_W'($urandom), c);
         check_all("R2 random write");
         run(int'($urandom_range(50, 600)), "R4 random run");
         if ($urandom_range(0, 4) == 0) begin
            stop_req = 1'b1;
            cyc();
            check_all("R7 random stop");
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule